// File: doc/BRIEF.md
# Widening Even-Lane Vector Shift Unit

This block executes one unsigned widening shift on a packed vector. It receives a source vector and a 32-bit instruction word, and it checks the fixed opcode bits of that word. From a combined size/immediate field it finds the source element width and the shift amount. It takes every even-numbered narrow lane of the source, zero-extends that lane to twice its width and shifts it left. Each result goes into the double-width destination lane that covers the same bits as the narrow lane pair it came from. Every destination lane is written: there is no predication.

The vector length is a parameter and must be a multiple of 64. A valid/ready handshake with one registered output stage moves each operation through the block. The registered output carries the result vector, the destination register index, a write enable, and a flag for an undefined encoding.

Top module: `wlane_shift_unit`

## Requirements
- R1: An instruction is recognised only when bits [31:23] are 010001010, bit 21 is 0 and bits [15:10] are 101010. Any other word gives out_undef=1, out_wen=0 and out_data all zero.
- R2: The size code is {insn[22], insn[20:19]}. Code 000 gives out_undef=1, out_wen=0 and out_data all zero.
- R3: For size code 001, the source elements are 8 bits and the shift is insn[18:16]. Destination lane e, at bits [16e+15:16e], equals source byte 2e zero-extended to 16 bits and shifted left.
- R4: For size codes 010 and 011, the source elements are 16 bits and the shift is {size code, insn[18:16]} minus 16, a value from 0 to 15. Destination lane e, at bits [32e+31:32e], equals source halfword 2e zero-extended to 32 bits and shifted left.
- R5: For size codes 1xx, the source elements are 32 bits and the shift is {size code, insn[18:16]} minus 32, a value from 0 to 31. Destination lane e, at bits [64e+63:64e], equals source word 2e zero-extended to 64 bits and shifted left.
- R6: The odd-numbered source lanes have no effect on out_data.
- R7: For a valid instruction, out_dst equals insn[4:0], out_wen=1 and out_undef=0.
- R8: in_ready is 1 whenever out_valid is 0 or out_ready is 1. An operation is taken in when in_valid and in_ready are both 1 at a clock edge, and out_valid is 1 after that edge.
- R9: While out_valid=1 and out_ready=0, all outputs hold their values. When out_ready=1 and no new operation is taken in, out_valid goes to 0.
- R10: After reset, out_valid, out_wen and out_undef are 0 and out_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The block can take an operation |
| insn | input | 32 | Instruction word |
| src | input | VLEN | Source vector |
| out_valid | output | 1 | A result is held |
| out_ready | input | 1 | The consumer takes the result |
| out_data | output | VLEN | Widened and shifted result vector |
| out_dst | output | 5 | Destination register index |
| out_wen | output | 1 | The result should be written |
| out_undef | output | 1 | The encoding is undefined |

## Verification
The bench drives the largest shift of each size with all-ones elements. A design that subtracted the element size wrongly, or that sign-extended the lanes, would put bits into the wrong positions or set bits in the upper half of a lane. It sends pairs of vectors that differ only in their odd lanes, which exposes a design that reads the odd lanes or picks the wrong lane. It also flips each fixed opcode bit one at a time and sends the reserved size code, so a loose decoder would still raise the write enable. Random backpressure on out_ready checks that results are held, not overwritten, while the consumer stalls.

// File: rtl/wlane_shift_unit.sv
module wlane_shift_unit #(
  parameter int VLEN = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     insn,
  input  logic [VLEN-1:0] src,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [VLEN-1:0] out_data,
  output logic [4:0]      out_dst,
  output logic            out_wen,
  output logic            out_undef
);
  localparam int L8  = VLEN / 16;
  localparam int L16 = VLEN / 32;
  localparam int L32 = VLEN / 64;

  logic            op_ok;
  logic [2:0]      tsz;
  logic [5:0]      fld;
  logic            bad;
  logic [2:0]      sh8;
  logic [3:0]      sh16;
  logic [4:0]      sh32;
  logic [VLEN-1:0] r8, r16, r32, res;
  logic            unused_zn;

  assign op_ok = (insn[31:23] == 9'b010001010) && !insn[21] && (insn[15:10] == 6'b101010);
  assign tsz   = {insn[22], insn[20:19]};
  assign fld   = {tsz, insn[18:16]};
  assign bad   = !op_ok || (tsz == 3'b000);
  assign unused_zn = ^insn[9:5];

  // fld - esize reduces to the bits below the leading one of the size code
  assign sh8  = fld[2:0];
  assign sh16 = fld[3:0];
  assign sh32 = fld[4:0];

  for (genvar g = 0; g < L8; g++) begin : g_b
    assign r8[16*g +: 16] = {8'b0, src[16*g +: 8]} << sh8;
  end
  for (genvar g = 0; g < L16; g++) begin : g_h
    assign r16[32*g +: 32] = {16'b0, src[32*g +: 16]} << sh16;
  end
  for (genvar g = 0; g < L32; g++) begin : g_w
    assign r32[64*g +: 64] = {32'b0, src[64*g +: 32]} << sh32;
  end

  always_comb begin
    if (bad)         res = '0;
    else if (tsz[2]) res = r32;
    else if (tsz[1]) res = r16;
    else             res = r8;
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_dst   <= '0;
      out_wen   <= 1'b0;
      out_undef <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= res;
      out_dst   <= insn[4:0];
      out_wen   <= !bad;
      out_undef <= bad;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R8
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_dst) && $stable(out_undef)); // R9
  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_undef |-> out_data == '0 && !out_wen); // R1
endmodule

// File: tb/wlane_shift_unit_test.sv
module wlane_shift_unit_test;
  localparam int V = 128;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, out_ready = 0;
  logic [31:0] insn = 0;
  logic [V-1:0] src = 0;
  logic out_valid, out_wen, out_undef;
  logic [V-1:0] out_data;
  logic [4:0] out_dst;

  wlane_shift_unit #(.VLEN(V)) uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .insn(insn), .src(src), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_dst(out_dst), .out_wen(out_wen), .out_undef(out_undef));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  string tag = "R10";
  bit rand_ready = 0;
  logic mv = 0, mwen = 0, mund = 0;
  logic [V-1:0] mdata = 0;
  logic [4:0] mdst = 0;
  logic [V-1:0] got[$];

  function automatic logic [V-1:0] ref_calc(input logic [31:0] w, input logic [V-1:0] s, output logic und);
    logic [V-1:0] r;
    logic [2:0] ts;
    int esz, sh;
    logic [63:0] el, val;
    r = '0;
    ts = {w[22], w[20:19]};
    und = !(w[31:23] == 9'b010001010 && w[21] == 1'b0 && w[15:10] == 6'b101010) || ts == 0;
    if (und) return r;
    esz = ts[2] ? 32 : (ts[1] ? 16 : 8);
    sh = int'({ts, w[18:16]}) - esz;
    for (int e = 0; e < V / (2 * esz); e++) begin
      el = 0;
      for (int b = 0; b < esz; b++) el[b] = s[2 * e * esz + b];
      val = el << sh;
      for (int b = 0; b < 2 * esz; b++) r[e * 2 * esz + b] = val[b];
    end
    return r;
  endfunction

  function automatic logic [31:0] enc(input logic [5:0] f, input logic [4:0] zd);
    return {9'b010001010, f[5], 1'b0, f[4:0], 6'b101010, 5'd3, zd};
  endfunction

  task automatic chk(input bit ok, input string t, input logic [V-1:0] act, input logic [V-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic u;
    logic [V-1:0] d;
    if (!rst_n) mv <= 0;
    else if (in_valid && (!mv || out_ready)) begin
      d = ref_calc(insn, src, u);
      mv <= 1; mdata <= d; mdst <= insn[4:0]; mund <= u; mwen <= !u;
    end else if (out_ready) mv <= 0;
  end

  always @(negedge clk) if (rst_n) begin
    chk(out_valid == mv, "R8/R9 valid", V'(out_valid), V'(mv));
    chk(in_ready == (!mv || out_ready), "R8 ready", V'(in_ready), V'(!mv || out_ready));
    if (mv) begin
      chk(out_data == mdata, tag, out_data, mdata);
      chk(out_dst == mdst && out_wen == mwen && out_undef == mund, mund ? "R1/R2 flags" : "R7 flags",
          V'({out_dst, out_wen, out_undef}), V'({mdst, mwen, mund}));
      if (out_ready) got.push_back(out_data);
    end
  end

  always @(posedge clk) begin
    #5;
    if (rand_ready) out_ready = $urandom_range(0, 2) != 0;
  end

  task automatic send(input logic [31:0] w, input logic [V-1:0] s);
    bit taken;
    @(posedge clk); #5;
    in_valid = 1; insn = w; src = s;
    do begin
      #5 taken = in_ready;
      @(posedge clk); #5;
    end while (!taken);
    in_valid = 0;
  endtask

  task automatic finish_sim;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #3000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    logic [V-1:0] a, b, ones;
    ones = '1;
    #25;
    // R10: reset values
    chk(!out_valid && !out_wen && !out_undef && out_data == 0, "R10 reset", out_data, '0);
    rst_n = 1;
    out_ready = 1;
    tag = "R3"; send(enc(6'b001000, 5'd1), {V/32{32'h1234_5678}}); send(enc(6'b001111, 5'd2), ones);
    tag = "R4"; send(enc(6'b010000, 5'd4), {V/32{32'h8765_4321}}); send(enc(6'b011111, 5'd5), ones);
    tag = "R5"; send(enc(6'b100000, 5'd6), {V/32{32'hdead_beef}}); send(enc(6'b111111, 5'd7), ones);
    tag = "R2"; send(enc(6'b000101, 5'd8), ones);
    tag = "R1";
    for (int i = 0; i < 32; i++) begin
      if (i < 5 || (i >= 16 && i < 19) || i == 22) continue;
      send(enc(6'b011010, 5'd9) ^ (32'd1 << i), ones);
    end
    tag = "R6";
    for (int k = 0; k < 3; k++) begin
      logic [31:0] w;
      w = enc(k == 0 ? 6'b001011 : (k == 1 ? 6'b010111 : 6'b101100), 5'd10);
      a = {V/32{$urandom}};
      b = a;
      for (int bi = 0; bi < V; bi++) if ((bi / (8 << k)) % 2 == 1) b[bi] = $urandom_range(0, 1);
      @(posedge clk); #5; got.delete();
      send(w, a); send(w, b);
      repeat (2) @(posedge clk); #6;
      chk(got.size() == 2 && got[0] == got[1], "R6 odd lanes", got.size() == 2 ? got[1] : '0, got.size() == 2 ? got[0] : '1);
    end
    tag = "R9"; rand_ready = 1;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] w;
      w = enc(6'($urandom_range(8, 63)), 5'($urandom));
      if ($urandom_range(0, 9) == 0) w = $urandom;
      send(w, {$urandom, $urandom, $urandom, $urandom});
    end
    rand_ready = 0;
    @(posedge clk); #5; out_ready = 1;
    repeat (4) @(posedge clk);
    finish_sim();
  end
endmodule